// File: doc/BRIEF.md
# ICMP Frame Filter with Slotted Receive Ring

This block sits beside a byte-wide Ethernet receive path. It watches every frame on the MAC-clock side and keeps only echo-style control traffic: IPv4 frames that carry ICMP and are addressed either to one programmed 48-bit station address or to the broadcast address. Every other frame is discarded. A byte-counting header matcher inspects the first 24 bytes of each frame. The frame is committed or abandoned on its last byte.

Kept frames land in a 16 KB buffer split into eight 2 KB slots, with one frame per slot. Bytes are written one at a time in the MAC clock. The buffer is read one 32-bit word at a time in the CPU clock. A 4-bit write pointer advances by one slot for each kept frame. The CPU owns a 4-bit read pointer and moves it forward as it consumes slots. Both pointers cross between the two clocks in Gray code. The ring counts as full when eight slots are outstanding, and frames that begin while it is full are dropped.

The receive stream uses valid/ready signalling. The block never applies back-pressure: ready is held high, and the only way a frame is refused is by dropping it. A beat is taken on any MAC clock edge where valid is high. The last-byte marker closes the frame. The station address and the control flags arrive through a plain register write port.

Top module: `icmp_slot_ring`

## Requirements
- R1: A frame is kept only if bytes 0..5 equal the programmed address, with byte 0 matching address bits 47:40 and byte 5 matching bits 7:0, or if all six bytes are 0xFF.
- R2: A frame is kept only if byte 12 is 0x08, byte 13 is 0x00, byte 14 is 0x45 and byte 23 is 0x01. A frame shorter than 24 bytes is never kept.
- R3: Byte k of the frame kept in slot s is stored at word address s*512 + k/4, in bits [8*(k%4)+7 : 8*(k%4)]. Read data appears on the CPU clock edge after the word address is presented.
- R4: The write pointer, seen on wr_ptr, advances by exactly one, modulo 16, for each kept frame and for nothing else. A rejected frame leaves it unchanged.
- R5: The ring is full when the write pointer minus the read pointer equals 8, modulo 16. A frame whose first byte arrives while the ring is full is dropped, and the slot contents already held stay unchanged.
- R6: A frame longer than 2048 bytes is dropped. A frame of exactly 2048 bytes can be kept.
- R7: A write with reg_sel = 2 loads reg_wdata[3:0] as the read pointer, which frees slots so that later frames can be kept. The pointer is meant to be advanced one step per write.
- R8: done becomes 1 once a write-pointer advance reaches the CPU side. It is cleared by a write with reg_sel = 3 and reg_wdata[31] = 1. If a set and a clear fall in the same cycle, the set wins.
- R9: rx_ready is 1 on every cycle after reset.
- R10: After reset, wr_ptr is 0 and done is 0. The station address registers load on writes with reg_sel = 0 (low 32 bits) and reg_sel = 1 (reg_wdata[15:0] as bits 47:32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mac_clk | input | 1 | Receive stream clock |
| mac_rst_n | input | 1 | Active-low asynchronous reset, MAC side |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Always 1; the block never stalls the stream |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| cpu_clk | input | 1 | CPU side clock |
| cpu_rst_n | input | 1 | Active-low asynchronous reset, CPU side |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 address low, 1 address high, 2 read pointer, 3 control |
| reg_wdata | input | 32 | Register write data |
| wr_ptr | output | 4 | Write pointer as seen in the CPU clock |
| done | output | 1 | Sticky flag showing that a new frame was kept |
| rd_addr | input | 12 | Buffer word address |
| rd_data | output | 32 | Buffer word, one cycle after rd_addr |

## Verification
The sticky done flag has a set path and a clear path. The set comes from the synchronised write pointer and the clear comes from a control write, and the two can land on the same CPU clock edge. The bench provokes this by timing a clear write so that it is sampled on the exact edge where a freshly advanced pointer first differs from its delayed copy. It then expects done to stay at 1, and a later clear with no new frame to bring it to 0. A second overlap occurs when a read-pointer update arrives while the ring is full at the wrap of the 4-bit pointers: a frame that starts before the update has crossed must still be dropped, and the next frame must be kept.

// File: rtl/icmp_ring_pkg.sv
package icmp_ring_pkg;

  // number of leading header bytes inspected by the matcher
  localparam int HDR_LEN    = 24;
  localparam int MAC_BYTES  = 6;
  localparam int IDX_ET_HI  = 12;
  localparam int IDX_ET_LO  = 13;
  localparam int IDX_VERHL  = 14;
  localparam int IDX_PROTO  = 23;

  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  VERHL_V4   = 8'h45;
  localparam logic [7:0]  PROTO_ICMP = 8'h01;
  localparam logic [7:0]  BCAST_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_RD_PTR  = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/ring_gray_sync.sv
module ring_gray_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  // Gray to binary: each bit is the xor of all Gray bits at or above it
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc        = acc ^ sync_q[i];
      bin_out[i] = acc;
    end
  end

endmodule

// File: rtl/icmp_hdr_filter.sv
module icmp_hdr_filter
  import icmp_ring_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  localparam int POS_W     = $clog2(SLOT_BYTES) + 1,
  localparam int OFF_W     = POS_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic [47:0]      station_mac,
  input  logic             ring_full,
  output logic             wr_en,
  output logic [OFF_W-1:0] wr_off,
  output logic             frame_ok
);

  logic [POS_W-1:0] pos_q;   // index of the byte now on the bus
  logic [4:0]       st_q;    // count of header bytes matched in a row
  logic             uc_q;    // destination still equals station address
  logic             bc_q;    // destination still equals broadcast
  logic             blk_q;   // frame started while the ring was full

  logic       first, in_hdr, room, seq_ok, byte_ok, hdr_done, blk_now;
  logic       uc_now, bc_now;
  logic [7:0] mac_byte;
  logic [4:0] st_d;

  assign first  = (pos_q == '0);
  assign in_hdr = (pos_q < POS_W'(HDR_LEN));
  assign room   = (pos_q < POS_W'(SLOT_BYTES));

  always_comb begin
    mac_byte = 8'h00;
    for (int k = 0; k < MAC_BYTES; k++) begin
      if (pos_q == POS_W'(k)) mac_byte = station_mac[8*(MAC_BYTES-1-k) +: 8];
    end
  end

  assign uc_now = (first | uc_q) & (rx_data == mac_byte);
  assign bc_now = (first | bc_q) & (rx_data == BCAST_BYTE);

  always_comb begin
    if (pos_q < POS_W'(MAC_BYTES))        byte_ok = uc_now | bc_now;
    else if (pos_q == POS_W'(IDX_ET_HI))  byte_ok = (rx_data == ETYPE_IPV4[15:8]);
    else if (pos_q == POS_W'(IDX_ET_LO))  byte_ok = (rx_data == ETYPE_IPV4[7:0]);
    else if (pos_q == POS_W'(IDX_VERHL))  byte_ok = (rx_data == VERHL_V4);
    else if (pos_q == POS_W'(IDX_PROTO))  byte_ok = (rx_data == PROTO_ICMP);
    else                                  byte_ok = 1'b1;
  end

  assign seq_ok   = in_hdr & (POS_W'(st_q) == pos_q);
  assign hdr_done = (st_q == 5'(HDR_LEN)) |
                    ((pos_q == POS_W'(HDR_LEN - 1)) & seq_ok & byte_ok);

  always_comb begin
    st_d = st_q;
    if (rx_valid) begin
      if (rx_last)                    st_d = 5'd0;
      else if (in_hdr)                st_d = (seq_ok && byte_ok) ? st_q + 5'd1 : 5'd0;
      else if (st_q != 5'(HDR_LEN))   st_d = 5'd0;
    end
  end

  assign blk_now  = first ? ring_full : blk_q;
  assign wr_en    = rx_valid & room & ~blk_now;
  assign wr_off   = pos_q[OFF_W-1:0];
  assign frame_ok = rx_valid & rx_last & hdr_done & room & ~blk_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      st_q  <= 5'd0;
      uc_q  <= 1'b0;
      bc_q  <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (rx_valid) begin
        uc_q  <= uc_now;
        bc_q  <= bc_now;
        blk_q <= blk_now;
        if (rx_last)   pos_q <= '0;
        else if (room) pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  // R2: the matcher never counts past the header length
  p_state_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_q <= 5'(HDR_LEN));

  // R4: every frame boundary returns the matcher to its idle point
  p_frame_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_last) |=> (pos_q == '0 && st_q == 5'd0));

  // R5: a frame opening on a full ring is not committed
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && pos_q == '0 && ring_full) |-> !frame_ok);

  // R6: bytes past the slot size are never written nor committed
  p_long_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && pos_q >= POS_W'(SLOT_BYTES)) |-> (!wr_en && !frame_ok));

endmodule

// File: rtl/slot_buffer.sv
module slot_buffer #(
  parameter int BYTES    = 16384,
  localparam int WORDS   = BYTES / 4,
  localparam int BA_W    = $clog2(BYTES),
  localparam int WA_W    = BA_W - 2
) (
  input  logic            wclk,
  input  logic            we,
  input  logic [BA_W-1:0] waddr,
  input  logic [7:0]      wdata,
  input  logic            rclk,
  input  logic [WA_W-1:0] raddr,
  output logic [31:0]     rdata
);

  // one byte-wide array per lane; lane = byte address modulo 4
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    logic [7:0] lane_q;

    always_ff @(posedge wclk) begin
      if (we && waddr[1:0] == 2'(l)) lane_mem[waddr[BA_W-1:2]] <= wdata;
    end

    always_ff @(posedge rclk) begin
      lane_q <= lane_mem[raddr];
    end

    assign rdata[8*l +: 8] = lane_q;
  end

endmodule

// File: rtl/icmp_slot_ring.sv
module icmp_slot_ring
  import icmp_ring_pkg::*;
#(
  parameter int SLOT_BYTES = 2048,
  parameter int PTR_W      = 4,
  localparam int SLOTS     = 1 << (PTR_W - 1),
  localparam int BUF_BYTES = SLOTS * SLOT_BYTES,
  localparam int OFF_W     = $clog2(SLOT_BYTES),
  localparam int BA_W      = OFF_W + PTR_W - 1,
  localparam int WA_W      = BA_W - 2
) (
  input  logic             mac_clk,
  input  logic             mac_rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             cpu_clk,
  input  logic             cpu_rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             done,
  input  logic [WA_W-1:0]  rd_addr,
  output logic [31:0]      rd_data
);

  // ---------------- CPU clock domain ----------------
  logic [31:0]      addr_lo_q;
  logic [15:0]      addr_hi_q;
  logic [PTR_W-1:0] rgray_q;
  logic [PTR_W-1:0] wp_cpu;
  logic [PTR_W-1:0] wp_prev_q;
  logic             done_q;
  logic             done_set, done_clr;

  assign done_set = (wp_cpu != wp_prev_q);
  assign done_clr = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[31];

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      rgray_q   <= '0;
      wp_prev_q <= '0;
      done_q    <= 1'b0;
    end else begin
      wp_prev_q <= wp_cpu;
      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (reg_wr) begin
        case (reg_sel)
          SEL_ADDR_LO: addr_lo_q <= reg_wdata;
          SEL_ADDR_HI: addr_hi_q <= reg_wdata[15:0];
          SEL_RD_PTR:  rgray_q   <= reg_wdata[PTR_W-1:0] ^ (reg_wdata[PTR_W-1:0] >> 1);
          default:     ;
        endcase
      end
    end
  end

  assign wr_ptr = wp_cpu;
  assign done   = done_q;

  // ---------------- MAC clock domain ----------------
  logic [PTR_W-1:0] wptr_q, wgray_q, rp_mac;
  logic             ring_full, commit, wr_en;
  logic [OFF_W-1:0] wr_off;

  assign rx_ready  = 1'b1;
  assign ring_full = ((wptr_q - rp_mac) == PTR_W'(SLOTS));

  always_ff @(posedge mac_clk or negedge mac_rst_n) begin
    if (!mac_rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (commit) begin
      wptr_q  <= wptr_q + PTR_W'(1);
      wgray_q <= (wptr_q + PTR_W'(1)) ^ ((wptr_q + PTR_W'(1)) >> 1);
    end
  end

  icmp_hdr_filter #(.SLOT_BYTES(SLOT_BYTES)) u_filter (
    .clk        (mac_clk),
    .rst_n      (mac_rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_last    (rx_last),
    .station_mac({addr_hi_q, addr_lo_q}),
    .ring_full  (ring_full),
    .wr_en      (wr_en),
    .wr_off     (wr_off),
    .frame_ok   (commit)
  );

  // read pointer into the MAC side, write pointer into the CPU side
  ring_gray_sync #(.W(PTR_W)) u_rp_sync (
    .clk    (mac_clk),
    .rst_n  (mac_rst_n),
    .gray_in(rgray_q),
    .bin_out(rp_mac)
  );

  ring_gray_sync #(.W(PTR_W)) u_wp_sync (
    .clk    (cpu_clk),
    .rst_n  (cpu_rst_n),
    .gray_in(wgray_q),
    .bin_out(wp_cpu)
  );

  slot_buffer #(.BYTES(BUF_BYTES)) u_buf (
    .wclk (mac_clk),
    .we   (wr_en),
    .waddr({wptr_q[PTR_W-2:0], wr_off}),
    .wdata(rx_data),
    .rclk (cpu_clk),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  // R5: occupancy never exceeds the slot count
  p_no_overflow_r5: assert property (@(posedge mac_clk) disable iff (!mac_rst_n)
    (wptr_q - rp_mac) <= PTR_W'(SLOTS));

  // R4: without a commit the write pointer holds
  p_ptr_hold_r4: assert property (@(posedge mac_clk) disable iff (!mac_rst_n)
    !commit |=> $stable(wptr_q));

  // R4: the crossing code moves by at most one bit per edge
  p_gray_step_r4: assert property (@(posedge mac_clk) disable iff (!mac_rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  // R9: the stream is never stalled
  p_ready_r9: assert property (@(posedge mac_clk) disable iff (!mac_rst_n)
    rx_ready);

  // R8: a pointer advance seen on the CPU side raises the flag
  p_done_set_r8: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (wp_cpu != wp_prev_q) |=> done);

  // R8: a clear with no concurrent advance drops the flag
  p_done_clear_r8: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (reg_wr && reg_sel == SEL_CTRL && reg_wdata[31] && wp_cpu == wp_prev_q) |=> !done);

endmodule

// File: tb/tb_icmp_slot_ring.sv
module tb_icmp_slot_ring;

  typedef logic [7:0] bytes_t[$];
  localparam logic [47:0] MAC = 48'h1122_3344_5566;
  localparam int SLOT_W = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [3:0]  wr_ptr;
  logic        done;
  logic [11:0] rd_addr = 12'h0;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  icmp_slot_ring dut (
    .mac_clk(clk), .mac_rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .cpu_clk(clk), .cpu_rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .wr_ptr(wr_ptr),
    .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, errors = 0, cyc = 0, seed = 3;
  bit run_model = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  // ---------------- behavioural reference ----------------
  int wp_m = 0, wp_s1 = 0, wp_s2 = 0, prev_m = 0, done_m = 0;
  int rp_reg = 0, rp_s1 = 0, rp_s2 = 0;
  bit fblk = 0;
  logic [7:0] fq[$];
  logic [7:0] slot_q[8][$];

  function automatic bit hdr_ok(logic [7:0] q[$]);
    bit uc = 1, bc = 1;
    if (q.size() < 24) return 0;
    for (int i = 0; i < 6; i++) begin
      if (q[i] != MAC[8*(5-i) +: 8]) uc = 0;
      if (q[i] != 8'hFF) bc = 0;
    end
    return (uc || bc) && q[12] == 8'h08 && q[13] == 8'h00 && q[14] == 8'h45 && q[23] == 8'h01;
  endfunction

  always @(negedge clk) begin
    if (run_model) begin
      bit set, clr, full;
      int nd;
      chk(wr_ptr == 4'(wp_s2), "R4 wr_ptr", wr_ptr, wp_s2);
      chk(done == 1'(done_m), "R8 done", done, done_m);
      chk(rx_ready == 1'b1, "R9 ready", rx_ready, 1);
      set = (wp_s2 != prev_m);
      clr = reg_wr && reg_sel == 2'd3 && reg_wdata[31];
      nd = set ? 1 : (clr ? 0 : done_m);
      prev_m = wp_s2;
      wp_s2 = wp_s1;
      wp_s1 = wp_m;
      full = (((wp_m - rp_s2) & 15) == 8);
      rp_s2 = rp_s1;
      rp_s1 = rp_reg;
      if (reg_wr && reg_sel == 2'd2) rp_reg = int'(reg_wdata[3:0]);
      if (rx_valid) begin
        if (fq.size() == 0) fblk = full;
        fq.push_back(rx_data);
        if (rx_last) begin
          if (!fblk && hdr_ok(fq) && fq.size() <= 2048) begin
            slot_q[wp_m & 7] = fq;
            wp_m = (wp_m + 1) & 15;
          end
          fq.delete();
        end
      end
      done_m = nd;
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic bytes_t mk(logic [47:0] da, logic [15:0] et, logic [7:0] vh,
                                logic [7:0] pr, int len);
    bytes_t q;
    for (int i = 0; i < len; i++) begin
      if (i < 6)        q.push_back(da[8*(5-i) +: 8]);
      else if (i < 12)  q.push_back(8'(8'hA0 + i));
      else if (i == 12) q.push_back(et[15:8]);
      else if (i == 13) q.push_back(et[7:0]);
      else if (i == 14) q.push_back(vh);
      else if (i == 23) q.push_back(pr);
      else              q.push_back(8'((i * 13 + seed) & 255));
    end
    seed += 17;
    return q;
  endfunction

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic send(bytes_t q, bit gaps);
    for (int i = 0; i < q.size(); i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(posedge clk); #2; rx_valid = 1'b0; rx_last = 1'b0;
      end
      @(posedge clk); #2;
      rx_valid = 1'b1; rx_data = q[i]; rx_last = (i == q.size() - 1);
    end
    @(posedge clk); #2; rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic wreg(logic [1:0] sel, logic [31:0] d);
    @(posedge clk); #2; reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #2; reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic verify_slot(int s, string req);
    int n = slot_q[s].size();
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] exp = 0, mask = 0;
      for (int l = 0; l < 4; l++) begin
        if (4 * w + l < n) begin
          exp[8*l +: 8]  = slot_q[s][4 * w + l];
          mask[8*l +: 8] = 8'hFF;
        end
      end
      @(posedge clk); #2; rd_addr = 12'(s * SLOT_W + w);
      @(posedge clk); @(negedge clk);
      chk(((rd_data ^ exp) & mask) == 0, req, rd_data & mask, exp);
    end
  endtask

  task automatic good(bit gaps);
    send(mk(MAC, 16'h0800, 8'h45, 8'h01, 64), gaps);
    idle(6);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    #1;
    chk(wr_ptr == 4'd0, "R10 reset wr_ptr", wr_ptr, 0);
    chk(done == 1'b0, "R10 reset done", done, 0);
    idle(3);
    rst_n = 1'b1;
    run_model = 1;
    wreg(2'd0, MAC[31:0]);
    wreg(2'd1, {16'h0, MAC[47:32]});
    idle(4);

    // R1 R2 R3 R4: unicast accept
    good(0);
    chk(wr_ptr == 4'd1, "R4 one accept", wr_ptr, 1);
    verify_slot(0, "R3 slot0 data");
    // R1: broadcast accept, with idle gaps in the stream
    send(mk(48'hFFFF_FFFF_FFFF, 16'h0800, 8'h45, 8'h01, 60), 1);
    idle(6);
    chk(wr_ptr == 4'd2, "R1 broadcast kept", wr_ptr, 2);
    verify_slot(1, "R3 slot1 data");
    // R1 R2: rejections
    send(mk(MAC ^ 48'h1, 16'h0800, 8'h45, 8'h01, 64), 0);
    send(mk(MAC, 16'h0806, 8'h45, 8'h01, 64), 0);
    send(mk(MAC, 16'h0800, 8'h46, 8'h01, 64), 1);
    send(mk(MAC, 16'h0800, 8'h45, 8'h06, 64), 0);
    send(mk(MAC, 16'h0800, 8'h45, 8'h01, 20), 0);
    idle(6);
    chk(wr_ptr == 4'd2, "R2 rejects leave pointer", wr_ptr, 2);
    verify_slot(1, "R4 slot1 kept after rejects");
    // R6: oversize and exact-size
    send(mk(MAC, 16'h0800, 8'h45, 8'h01, 2049), 0);
    idle(6);
    chk(wr_ptr == 4'd2, "R6 oversize dropped", wr_ptr, 2);
    send(mk(MAC, 16'h0800, 8'h45, 8'h01, 2048), 0);
    idle(6);
    chk(wr_ptr == 4'd3, "R6 full-size kept", wr_ptr, 3);
    verify_slot(2, "R6 slot2 data");

    // R8: clear alone, then clear colliding with a set
    wreg(2'd3, 32'h8000_0000);
    idle(2);
    chk(done == 1'b0, "R8 clear", done, 0);
    send(mk(MAC, 16'h0800, 8'h45, 8'h01, 40), 0);
    idle(1);
    wreg(2'd3, 32'h8000_0000);
    idle(2);
    chk(done == 1'b1, "R8 set wins over clear", done, 1);
    wreg(2'd3, 32'h8000_0000);
    idle(2);
    chk(done == 1'b0, "R8 later clear", done, 0);

    // R5: fill the ring to eight outstanding
    for (int i = 0; i < 4; i++) good(i[0]);
    chk(wr_ptr == 4'd8, "R5 ring filled", wr_ptr, 8);
    good(0);
    chk(wr_ptr == 4'd8, "R5 dropped while full", wr_ptr, 8);
    verify_slot(0, "R5 oldest slot untouched");
    verify_slot(7, "R3 slot7 data");
    // R7: free one slot
    wreg(2'd2, 32'd1);
    idle(4);
    good(0);
    chk(wr_ptr == 4'd9, "R7 accepted after release", wr_ptr, 9);
    verify_slot(0, "R7 slot0 reused");

    // R5 at pointer wrap
    for (int p = 2; p <= 8; p++) begin wreg(2'd2, 32'(p)); idle(1); end
    idle(4);
    for (int i = 0; i < 7; i++) good(0);
    chk(wr_ptr == 4'd0, "R4 pointer wrap", wr_ptr, 0);
    good(1);
    chk(wr_ptr == 4'd0, "R5 full at wrap", wr_ptr, 0);
    verify_slot(7, "R5 slot7 untouched");
    wreg(2'd2, 32'd9);
    idle(4);
    good(0);
    chk(wr_ptr == 4'd1, "R7 accepted after wrap release", wr_ptr, 1);
    verify_slot(0, "R3 slot0 after wrap");

    idle(4);
    finish_run();
  end

endmodule